// File: doc/BRIEF.md
# Parallel Port Bidirectional Handshake Controller

This block is the host-side sequencer of an enhanced-capability parallel port. It moves bytes out to a peripheral with a strobe that is fully interlocked with the peripheral's busy line. It moves bytes back in with a host-acknowledge that is interlocked with the peripheral's acknowledge. It also handles the hand-over of the shared eight-bit data bus between the two directions. A command flag travels with every byte. Going forward it is carried on the host-acknowledge line. Coming back it is carried on the busy line.

Internal logic sees a transmit stream (`tx_valid`/`tx_ready` with a byte and a command flag), a receive pulse stream, and a direction request. The bus is handed to the peripheral in three steps: the host first releases its data drivers, then pulls the direction line low, and only starts reverse transfers after the peripheral acknowledges the turnaround. Handing the bus back works the same way in the other direction. Every wait on the peripheral is guarded by a programmable timeout. When the timeout expires, the controller returns to forward idle. All pin inputs pass through a two-flop synchronizer, and the internal reset is released synchronously.

Top module: `pport_hs_ctrl`

## Requirements
- R1: After reset: `nstrobe`, `host_ack`, `ninit` and `pd_oe` are high, `tx_ready` is high, and `rx_valid` and `tmo_err` are low.
- R2: A byte is taken when `tx_valid` and `tx_ready` are both high at a clock edge. `nstrobe` goes low only after `busy` has been seen low. `nstrobe` returns high on the third clock edge after `busy` rises. Throughout the strobe, `host_ack` is 1 for a data byte and 0 for a command byte (`tx_cmd`=1).
- R3: While `nstrobe` is low, `pd_out` and `host_ack` do not change.
- R4: On a reverse request, `pd_oe` goes low at least one cycle before `ninit` falls. `host_ack` stays high until `nackrev` low has been observed.
- R5: In reverse, `host_ack` low requests a byte. When `nack` falls, `rx_valid` pulses for one cycle with `rx_data` equal to `pd_in`. `rx_cmd` is 1 when `busy` was low and 0 when `busy` was high. `host_ack` then returns high.
- R6: When `dir_rev_req` drops in reverse, `ninit` returns high. `pd_oe` and `tx_ready` rise only after `nackrev` is high again, and forward transfers then resume.
- R7: `pd_oe` is low whenever `ninit` is low, and it is low whenever the peripheral drives the bus.
- R8: `nselectin` is held high at all times.
- R9: In the forward direction, `fault_hint` follows an inverted `nfault` after synchronization. It does not turn the bus around on its own.
- R10: If a wait state lasts `tmo_limit`+1 cycles, `tmo_err` pulses for one cycle. At that moment `nstrobe`, `host_ack`, `ninit` and `pd_oe` are already back high (forward idle).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Transmit byte can be taken (forward idle) |
| tx_data | input | DW | Transmit byte |
| tx_cmd | input | 1 | Transmit byte is a command |
| rx_valid | output | 1 | One-cycle pulse: received byte present |
| rx_data | output | DW | Received byte |
| rx_cmd | output | 1 | Received byte is a command |
| dir_rev_req | input | 1 | 1 asks for reverse direction, 0 for forward |
| tmo_limit | input | TMO_W | Wait-state timeout in cycles |
| tmo_err | output | 1 | One-cycle pulse on timeout |
| fault_hint | output | 1 | Peripheral asks for reverse (forward only) |
| pd_out | output | DW | Data bus value driven by the host |
| pd_oe | output | 1 | Host data driver enable |
| pd_in | input | DW | Data bus value as seen at the pins |
| nstrobe | output | 1 | Forward strobe, active low |
| host_ack | output | 1 | Command/data flag forward, byte request (low) reverse |
| ninit | output | 1 | Direction: low = reverse |
| nselectin | output | 1 | Held high |
| nack | input | 1 | Peripheral data valid in reverse, active low |
| busy | input | 1 | Forward flow control, reverse command/data flag |
| nackrev | input | 1 | Peripheral turnaround acknowledge, low = reverse |
| nfault | input | 1 | Peripheral reverse hint, active low |

## Verification
A pin change reaches the state machine two edges after it occurs. The registered pin outputs move on the third edge. The bench therefore counts exactly three edges from raising `busy` to the release of `nstrobe`. `rx_valid` is expected on the third edge after `nack` falls and is matched against the scoreboard queue at that moment. A timeout is due `tmo_limit`+1 edges after the wait state is entered. The bench counts edges from that entry (the byte acceptance, or the falling edge of `host_ack`) and compares the count exactly. All pins are driven and sampled on the falling clock edge, so every count refers to whole rising edges.

// File: rtl/pport_pkg.sv
package pport_pkg;

  typedef enum logic [3:0] {
    ST_F_IDLE,
    ST_F_SETUP,
    ST_F_STROBE,
    ST_R_OFF,
    ST_R_TURN,
    ST_R_IDLE,
    ST_R_REQ,
    ST_R_REL,
    ST_F_TURN
  } pp_state_e;

  // states that wait on a peripheral response and are timed
  function automatic logic is_wait(input pp_state_e s);
    return (s == ST_F_SETUP) || (s == ST_F_STROBE) || (s == ST_R_TURN) ||
           (s == ST_R_REQ) || (s == ST_R_REL) || (s == ST_F_TURN);
  endfunction

  // states in which the host owns the data bus
  function automatic logic is_host_owner(input pp_state_e s);
    return (s == ST_F_IDLE) || (s == ST_F_SETUP) || (s == ST_F_STROBE);
  endfunction

  // states in which the direction line requests reverse
  function automatic logic is_rev_dir(input pp_state_e s);
    return (s == ST_R_TURN) || (s == ST_R_IDLE) || (s == ST_R_REQ) ||
           (s == ST_R_REL);
  endfunction

endpackage

// File: rtl/pport_sync.sv
module pport_sync #(
  parameter int             W       = 1,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  genvar gi;
  generate
    for (gi = 0; gi < W; gi++) begin : g_bit
      logic meta_q;
      logic sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          meta_q <= RST_VAL[gi];
          sync_q <= RST_VAL[gi];
        end else begin
          meta_q <= d[gi];
          sync_q <= meta_q;
        end
      end
      assign q[gi] = sync_q;
    end
  endgenerate

endmodule

// File: rtl/pport_timeout.sv
module pport_timeout #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          restart,
  input  logic [CW-1:0] limit,
  output logic          expired
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          at_limit;

  assign at_limit = (cnt_q >= limit);
  assign expired  = run && !restart && at_limit;

  always_comb begin
    cnt_d = cnt_q;
    if (!run || restart || at_limit) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // expiry always clears the count for the next wait (R10)
  assert_tmo_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    expired |=> (cnt_q == '0));

endmodule

// File: rtl/pport_hs_ctrl.sv
module pport_hs_ctrl
  import pport_pkg::*;
#(
  parameter int DW    = 8,
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_valid,
  output logic             tx_ready,
  input  logic [DW-1:0]    tx_data,
  input  logic             tx_cmd,
  output logic             rx_valid,
  output logic [DW-1:0]    rx_data,
  output logic             rx_cmd,
  input  logic             dir_rev_req,
  input  logic [TMO_W-1:0] tmo_limit,
  output logic             tmo_err,
  output logic             fault_hint,
  output logic [DW-1:0]    pd_out,
  output logic             pd_oe,
  input  logic [DW-1:0]    pd_in,
  output logic             nstrobe,
  output logic             host_ack,
  output logic             ninit,
  output logic             nselectin,
  input  logic             nack,
  input  logic             busy,
  input  logic             nackrev,
  input  logic             nfault
);

  localparam int            SW       = DW + 4;
  localparam logic [SW-1:0] SYNC_RST = {4'b1111, {DW{1'b0}}};

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // pin input synchronization
  logic [SW-1:0] sync_q;
  logic          nfault_s, nackrev_s, nack_s, busy_s;
  logic [DW-1:0] pd_in_s;

  pport_sync #(.W(SW), .RST_VAL(SYNC_RST)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     ({nfault, nackrev, nack, busy, pd_in}),
    .q     (sync_q)
  );
  assign {nfault_s, nackrev_s, nack_s, busy_s, pd_in_s} = sync_q;

  // state machine
  pp_state_e state_q, state_d, prog_d;
  logic      accept, capture, tmo_hit, restart, cmd_q, cmd_d, hack_d;

  always_comb begin
    prog_d  = state_q;
    accept  = 1'b0;
    capture = 1'b0;
    unique case (state_q)
      ST_F_IDLE: begin
        if (dir_rev_req) begin
          prog_d = ST_R_OFF;
        end else if (tx_valid) begin
          accept = 1'b1;
          prog_d = ST_F_SETUP;
        end
      end
      ST_F_SETUP:  if (!busy_s)    prog_d = ST_F_STROBE;
      ST_F_STROBE: if (busy_s)     prog_d = ST_F_IDLE;
      ST_R_OFF:                    prog_d = ST_R_TURN;
      ST_R_TURN:   if (!nackrev_s) prog_d = ST_R_IDLE;
      ST_R_IDLE:   prog_d = dir_rev_req ? ST_R_REQ : ST_F_TURN;
      ST_R_REQ: begin
        if (!nack_s) begin
          capture = 1'b1;
          prog_d  = ST_R_REL;
        end else if (!dir_rev_req) begin
          prog_d = ST_R_IDLE;
        end
      end
      ST_R_REL:    if (nack_s)     prog_d = ST_R_IDLE;
      ST_F_TURN:   if (nackrev_s)  prog_d = ST_F_IDLE;
      default:                     prog_d = ST_F_IDLE;
    endcase
  end

  assign restart = (prog_d != state_q);

  pport_timeout #(.CW(TMO_W)) u_tmo (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .run     (is_wait(state_q)),
    .restart (restart),
    .limit   (tmo_limit),
    .expired (tmo_hit)
  );

  assign state_d = tmo_hit ? ST_F_IDLE : prog_d;
  assign cmd_d   = accept ? tx_cmd : cmd_q;

  always_comb begin
    unique case (state_d)
      ST_F_SETUP, ST_F_STROBE: hack_d = !cmd_d;
      ST_R_REQ:                hack_d = 1'b0;
      default:                 hack_d = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q  <= ST_F_IDLE;
      nstrobe  <= 1'b1;
      host_ack <= 1'b1;
      ninit    <= 1'b1;
      pd_oe    <= 1'b1;
      pd_out   <= '0;
      cmd_q    <= 1'b0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
      rx_cmd   <= 1'b0;
      tmo_err  <= 1'b0;
    end else begin
      state_q  <= state_d;
      nstrobe  <= (state_d != ST_F_STROBE);
      host_ack <= hack_d;
      ninit    <= !is_rev_dir(state_d);
      pd_oe    <= is_host_owner(state_d);
      rx_valid <= capture;
      tmo_err  <= tmo_hit;
      if (accept) begin
        pd_out <= tx_data;
        cmd_q  <= tx_cmd;
      end
      if (capture) begin
        rx_data <= pd_in_s;
        rx_cmd  <= !busy_s;
      end
    end
  end

  assign tx_ready   = (state_q == ST_F_IDLE) && !dir_rev_req;
  assign nselectin  = 1'b1;
  assign fault_hint = !nfault_s && is_host_owner(state_q);

  // strobe only after busy was seen low (R2)
  assert_strobe_waits_busy_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(nstrobe) |-> !$past(busy_s));

  // strobe released only on busy high or timeout (R2)
  assert_strobe_release_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($rose(nstrobe) && !tmo_err) |-> $past(busy_s));

  // data and flag frozen while strobe is low (R3)
  assert_data_stable_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!nstrobe && $past(!nstrobe)) |-> ($stable(pd_out) && $stable(host_ack)));

  // drivers off before direction flips (R4)
  assert_oe_before_init_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(ninit) |-> (!pd_oe && !$past(pd_oe)));

  // one-cycle receive pulse with the request withdrawn (R5)
  assert_rx_pulse_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rx_valid |-> (host_ack && !$past(host_ack) && $past(!nack_s)));

  // drivers return only after peripheral released the bus (R6)
  assert_oe_after_ack_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($rose(pd_oe) && !tmo_err) |-> $past(nackrev_s));

  // never drive in reverse direction (R7)
  assert_no_drive_rev_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ninit |-> !pd_oe);

  // timeout lands in forward idle (R10)
  assert_tmo_idle_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    tmo_err |-> (nstrobe && ninit && host_ack && pd_oe));

endmodule

// File: tb/pport_hs_ctrl_test.sv
module pport_hs_ctrl_test;

  localparam int DW    = 8;
  localparam int TMO_W = 16;
  localparam int LIM   = 40;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic             rst_n;
  logic             tx_valid, tx_ready, tx_cmd;
  logic [DW-1:0]    tx_data;
  logic             rx_valid, rx_cmd;
  logic [DW-1:0]    rx_data;
  logic             dir_rev_req;
  logic [TMO_W-1:0] tmo_limit;
  logic             tmo_err, fault_hint;
  logic [DW-1:0]    pd_out, pd_in;
  logic             pd_oe, nstrobe, host_ack, ninit, nselectin;
  logic             nack, nackrev, nfault;
  logic             busy_f, busy_r, hold_busy, rev_data_en;
  logic             busy;

  assign busy = busy_f | busy_r | hold_busy;

  pport_hs_ctrl #(.DW(DW), .TMO_W(TMO_W)) uut (
    .clk(clk), .rst_n(rst_n),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_cmd(tx_cmd),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_cmd(rx_cmd),
    .dir_rev_req(dir_rev_req), .tmo_limit(tmo_limit), .tmo_err(tmo_err),
    .fault_hint(fault_hint), .pd_out(pd_out), .pd_oe(pd_oe), .pd_in(pd_in),
    .nstrobe(nstrobe), .host_ack(host_ack), .ninit(ninit), .nselectin(nselectin),
    .nack(nack), .busy(busy), .nackrev(nackrev), .nfault(nfault)
  );

  int checks = 0;
  int failures = 0;
  int rx_seen = 0;

  logic [DW:0] exp_fwd[$];  // {host_ack expected, byte}
  logic [DW:0] per_q[$];    // {cmd, byte} the peripheral will send
  logic [DW:0] exp_rx[$];   // {cmd, byte} expected at rx

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // driver: offer a byte; record expectation when a strobe is expected
  task automatic send_byte(input logic [DW-1:0] b, input logic c, input bit expect_strobe);
    while (!tx_ready) @(negedge clk);
    tx_valid = 1'b1; tx_data = b; tx_cmd = c;
    if (expect_strobe) exp_fwd.push_back({~c, b});
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  // forward peripheral + monitor
  initial begin
    busy_f = 1'b0;
    forever begin
      @(negedge clk);
      if (!nstrobe && !busy) begin
        logic [DW:0] got, want;
        logic [DW-1:0] held;
        bit stable_ok;
        int n;
        got = {host_ack, pd_out};
        held = pd_out;
        if (exp_fwd.size() == 0) begin
          check(0, "R2 unexpected strobe", got, 0);
        end else begin
          want = exp_fwd.pop_front();
          check(got == want, "R2 strobed byte and flag", got, want);
        end
        check(pd_oe == 1'b1, "R7 host drives during strobe", pd_oe, 1);
        repeat (2) @(negedge clk);
        busy_f = 1'b1;
        n = 0;
        stable_ok = 1'b1;
        while (!nstrobe) begin
          if (pd_out != held) stable_ok = 1'b0;
          @(negedge clk);
          n++;
        end
        check(n == 3, "R2 strobe release latency", n, 3);
        check(stable_ok, "R3 data held during strobe", pd_out, held);
        @(negedge clk);
        busy_f = 1'b0;
      end
    end
  end

  // turnaround responder
  initial begin
    nackrev = 1'b1;
    forever begin
      @(negedge clk);
      if (ninit != nackrev) begin
        logic tgt;
        tgt = ninit;
        repeat (2) @(negedge clk);
        if (ninit == tgt) begin
          if (!tgt) begin
            check(pd_oe == 1'b0, "R4 drivers off before reverse ack", pd_oe, 0);
            check(host_ack == 1'b1, "R4 no request before reverse ack", host_ack, 1);
          end
          nackrev = tgt;
        end
      end
    end
  end

  // reverse data source
  initial begin
    nack = 1'b1; busy_r = 1'b0; pd_in = '0;
    forever begin
      @(negedge clk);
      if (rev_data_en && !ninit && !nackrev && !host_ack && nack && per_q.size() != 0) begin
        logic [DW:0] item;
        item = per_q.pop_front();
        check(pd_oe == 1'b0 && nselectin == 1'b1, "R7 host off while peripheral drives",
              {pd_oe, nselectin}, 1);
        pd_in = item[DW-1:0];
        busy_r = ~item[DW];   // busy low marks a command
        exp_rx.push_back(item);
        @(negedge clk);
        nack = 1'b0;
        while (!host_ack) @(negedge clk);
        @(negedge clk);
        nack = 1'b1;
        busy_r = 1'b0;
      end
    end
  end

  // receive monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rx_valid) begin
        logic [DW:0] want;
        rx_seen++;
        if (exp_rx.size() == 0) begin
          check(0, "R5 unexpected rx", {rx_cmd, rx_data}, 0);
        end else begin
          want = exp_rx.pop_front();
          check({rx_cmd, rx_data} == want, "R5 received byte and flag",
                {rx_cmd, rx_data}, want);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    check(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int n;
    bit oe_ok;
    rst_n = 1'b0; tx_valid = 1'b0; tx_data = '0; tx_cmd = 1'b0;
    dir_rev_req = 1'b0; tmo_limit = LIM[TMO_W-1:0]; nfault = 1'b1;
    hold_busy = 1'b0; rev_data_en = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check({nstrobe, host_ack, ninit, pd_oe} == 4'hF, "R1 pin idle levels",
          {nstrobe, host_ack, ninit, pd_oe}, 4'hF);
    check(tx_ready == 1'b1, "R1 tx_ready", tx_ready, 1);
    check(rx_valid == 1'b0 && tmo_err == 1'b0, "R1 pulses low", {rx_valid, tmo_err}, 0);
    check(nselectin == 1'b1, "R8 select-in high", nselectin, 1);

    // R2 forward bytes, data and command
    send_byte(8'hA5, 1'b0, 1'b1);
    send_byte(8'h3C, 1'b1, 1'b1);
    send_byte(8'h00, 1'b0, 1'b1);
    send_byte(8'hFF, 1'b1, 1'b1);
    while (exp_fwd.size() != 0 || !tx_ready) @(negedge clk);

    // R9 fault hint, no turnaround
    nfault = 1'b0;
    repeat (4) @(negedge clk);
    check(fault_hint == 1'b1, "R9 hint follows fault", fault_hint, 1);
    check(ninit == 1'b1 && pd_oe == 1'b1, "R9 no self turnaround", {ninit, pd_oe}, 3);
    nfault = 1'b1;
    repeat (4) @(negedge clk);
    check(fault_hint == 1'b0, "R9 hint clears", fault_hint, 0);

    // R4/R5 reverse transfers
    per_q.push_back({1'b0, 8'h5A});
    per_q.push_back({1'b1, 8'hC3});
    per_q.push_back({1'b0, 8'h81});
    dir_rev_req = 1'b1;
    while (rx_seen < 3) @(negedge clk);
    check(nselectin == 1'b1, "R8 select-in high in reverse", nselectin, 1);

    // R6 back to forward
    dir_rev_req = 1'b0;
    oe_ok = 1'b1;
    while (!tx_ready) begin
      @(negedge clk);
      if (pd_oe && !nackrev) oe_ok = 1'b0;
    end
    check(oe_ok, "R6 drivers wait for forward ack", oe_ok, 1);
    check(ninit == 1'b1 && pd_oe == 1'b1, "R6 forward restored", {ninit, pd_oe}, 3);
    send_byte(8'h96, 1'b0, 1'b1);
    while (exp_fwd.size() != 0 || !tx_ready) @(negedge clk);

    // R10 forward timeout: busy stuck high
    hold_busy = 1'b1;
    repeat (4) @(negedge clk);
    send_byte(8'h11, 1'b0, 1'b0);
    n = 0;
    while (!tmo_err && n < 200) begin @(negedge clk); n++; end
    check(n == LIM + 1, "R10 forward timeout cycles", n, LIM + 1);
    check({nstrobe, host_ack, ninit, pd_oe} == 4'hF, "R10 forward idle after timeout",
          {nstrobe, host_ack, ninit, pd_oe}, 4'hF);
    @(negedge clk);
    check(tmo_err == 1'b0, "R10 single-cycle error pulse", tmo_err, 0);
    hold_busy = 1'b0;
    repeat (4) @(negedge clk);

    // R10 reverse timeout: peripheral never answers
    rev_data_en = 1'b0;
    dir_rev_req = 1'b1;
    n = 0;
    while (host_ack && n < 200) begin @(negedge clk); n++; end
    n = 0;
    while (!tmo_err && n < 200) begin @(negedge clk); n++; end
    check(n == LIM + 1, "R10 reverse timeout cycles", n, LIM + 1);
    check({host_ack, ninit, pd_oe} == 3'h7, "R10 reverse abort to forward",
          {host_ack, ninit, pd_oe}, 3'h7);
    dir_rev_req = 1'b0;
    rev_data_en = 1'b1;
    while (!tx_ready || !nackrev) @(negedge clk);
    repeat (4) @(negedge clk);
    send_byte(8'h42, 1'b1, 1'b1);
    while (exp_fwd.size() != 0 || !tx_ready) @(negedge clk);
    repeat (4) @(negedge clk);

    finish_run();
  end

endmodule